// File: doc/BRIEF.md
# Pairing Frame Byte Generator

This block builds a 16-byte pairing frame and sends it out one byte at a time over a valid/ready byte stream. The frame is made from a 32-bit device identifier, a channel count and a 2-bit mode code. A start pulse captures these three inputs and begins a new frame, so every frame is built again from the values present at its own start. A last flag marks the final byte.

The frame carries two 16-bit checksums, each sent most significant byte first. They are formed by one running sum that begins at a fixed bias of 368. The first checksum covers the eight identifier bytes. The second continues the same sum over the following six bytes, which include the first checksum. Both are computed while the bytes stream out, so no frame buffer is needed. One byte of the frame depends on both the mode code and the channel count.

Top module: `bind_frame_gen`

## Requirements
- R1: After reset the output is idle, with `out_valid_o` and `out_last_o` both low, and it stays idle until a start pulse.
- R2: Bytes 0 to 3 are the bitwise inverse of identifier bytes 0 to 3, where identifier byte k is `id_i[8k+7:8k]`. Bytes 4 to 7 repeat bytes 0 to 3.
- R3: Byte 8 is the high byte and byte 9 the low byte of (368 + the sum of bytes 0 to 7), taken modulo 65536.
- R4: Byte 10 is 0x01, byte 11 is the captured channel count, and byte 13 is 0x00.
- R5: For mode 0 (legacy 22 ms), byte 12 is 0x01 when the count is below 8 and 0x02 otherwise. For mode 1 (legacy 11 ms), byte 12 is 0x12.
- R6: For mode 2 (enhanced 22 ms), byte 12 is 0xA2 when the count is below 8 and 0xB2 otherwise. For mode 3 (enhanced 11 ms or auto), byte 12 is 0xB2.
- R7: Bytes 14 (high) and 15 (low) hold the running sum of R3 after bytes 8 to 13 have also been added to it, taken modulo 65536.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the byte on the output and the last flag hold unchanged.
- R9: `out_last_o` is high only together with byte 15. After byte 15 is accepted, `out_valid_o` goes low in the next cycle.
- R10: A start pulse during a frame is ignored. The frame in progress continues unchanged, and changes to the identifier, count or mode inputs made during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start_i | input | 1 | Pulse that begins a frame when the block is idle |
| id_i | input | 32 | Device identifier; byte k is bits 8k+7:8k |
| chan_cnt_i | input | 4 | Channel count, 4 to 12 |
| mode_i | input | 2 | Mode code: 0 legacy 22 ms, 1 legacy 11 ms, 2 enhanced 22 ms, 3 enhanced 11 ms or auto |
| out_data_o | output | 8 | Frame byte |
| out_valid_o | output | 1 | Byte on `out_data_o` is valid |
| out_ready_i | input | 1 | Consumer accepts the byte |
| out_last_o | output | 1 | Marks byte 15 |

## Verification
A wrong byte index or a wrong running sum shows up directly in the stream. An index error gives a wrong byte or a misplaced last flag within one handshake. A sum error appears at byte 8 at the earliest and always reaches bytes 14 and 15, because the second checksum covers the first. If the sum is added at the wrong handshake, byte 9 differs from the low byte that goes with byte 8. If the block drops or repeats a handshake, the last flag falls on the wrong byte and the frame length differs from 16. If the inputs are not held in capture registers, changing the identifier mid-frame corrupts the very next byte.

// File: rtl/bind_frame_pkg.sv
package bind_frame_pkg;

    localparam int BYTE_W    = 8;
    localparam int ID_BYTES  = 4;
    localparam int FRAME_LEN = 16;
    localparam int SUM_W     = 16;
    localparam int CNT_W     = 4;
    localparam int SUM_BIAS  = 368;
    localparam int FEW_CH    = 8;

    typedef enum logic [1:0] {
        MODE_LEG22 = 2'd0,
        MODE_LEG11 = 2'd1,
        MODE_ENH22 = 2'd2,
        MODE_ENH11 = 2'd3
    } bind_mode_e;

endpackage

// File: rtl/bind_mode_code.sv
module bind_mode_code
    import bind_frame_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int THRESH = FEW_CH
) (
    input  bind_mode_e      mode_i,
    input  logic [CW-1:0]   cnt_i,
    output logic [7:0]      code_o
);
    logic few;
    assign few = (int'(cnt_i) < THRESH);

    always_comb begin
        unique case (mode_i)
            MODE_LEG22: code_o = few ? 8'h01 : 8'h02;
            MODE_LEG11: code_o = 8'h12;
            MODE_ENH22: code_o = few ? 8'hA2 : 8'hB2;
            default:    code_o = 8'hB2;
        endcase
    end
endmodule

// File: rtl/bind_byte_mux.sv
module bind_byte_mux
    import bind_frame_pkg::*;
#(
    parameter int NB = ID_BYTES,
    parameter int CW = CNT_W,
    parameter int SW = SUM_W,
    parameter int IW = $clog2(FRAME_LEN)
) (
    input  logic [IW-1:0]      idx_i,
    input  logic [NB*8-1:0]    id_i,
    input  logic [CW-1:0]      cnt_i,
    input  logic [7:0]         mode_code_i,
    input  logic [SW-1:0]      sum_i,
    output logic [7:0]         byte_o
);
    logic [7:0] inv_b [NB];

    for (genvar g = 0; g < NB; g++) begin : g_inv
        assign inv_b[g] = ~id_i[g*8 +: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        unique case (idx_i)
            4'd0, 4'd4:   byte_o = inv_b[0];
            4'd1, 4'd5:   byte_o = inv_b[1];
            4'd2, 4'd6:   byte_o = inv_b[2];
            4'd3, 4'd7:   byte_o = inv_b[3];
            4'd8, 4'd14:  byte_o = sum_i[SW-1 -: 8];
            4'd9, 4'd15:  byte_o = sum_i[7:0];
            4'd10:        byte_o = 8'h01;
            4'd11:        byte_o = 8'(cnt_i);
            4'd12:        byte_o = mode_code_i;
            default:      byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/bind_frame_gen.sv
module bind_frame_gen
    import bind_frame_pkg::*;
#(
    parameter int NB   = ID_BYTES,
    parameter int CW   = CNT_W,
    parameter int SW   = SUM_W,
    parameter int BIAS = SUM_BIAS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [31:0]     id_i,
    input  logic [3:0]      chan_cnt_i,
    input  logic [1:0]      mode_i,
    output logic [7:0]      out_data_o,
    output logic            out_valid_o,
    input  logic            out_ready_i,
    output logic            out_last_o
);
    localparam int IW = $clog2(FRAME_LEN);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);
    localparam logic [IW-1:0] CHK1_HI  = IW'(8);
    localparam logic [IW-1:0] CHK1_LO  = IW'(9);
    localparam logic [IW-1:0] CHK2_HI  = IW'(14);

    typedef struct packed {
        logic            active;
        logic [IW-1:0]   idx;
        logic [SW-1:0]   sum;
        logic [NB*8-1:0] id;
        logic [CW-1:0]   cnt;
        bind_mode_e      mode;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [7:0] mode_code;
    logic [7:0] cur_byte;
    logic       fire;

    bind_mode_code #(.CW(CW), .THRESH(FEW_CH)) u_mode (
        .mode_i (st_q.mode),
        .cnt_i  (st_q.cnt),
        .code_o (mode_code)
    );

    bind_byte_mux #(.NB(NB), .CW(CW), .SW(SW), .IW(IW)) u_mux (
        .idx_i       (st_q.idx),
        .id_i        (st_q.id),
        .cnt_i       (st_q.cnt),
        .mode_code_i (mode_code),
        .sum_i       (st_q.sum),
        .byte_o      (cur_byte)
    );

    assign fire = st_q.active && out_ready_i;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_i) begin
                st_d.active = 1'b1;
                st_d.idx    = '0;
                st_d.sum    = SW'(BIAS);
                st_d.id     = id_i;
                st_d.cnt    = chan_cnt_i;
                st_d.mode   = bind_bode_cast(mode_i);
            end
        end else if (fire) begin
            // checksum bytes are folded in on the second half so the sum stays put while sent
            if (st_q.idx == CHK1_LO)
                st_d.sum = st_q.sum + SW'(st_q.sum[SW-1 -: 8]) + SW'(st_q.sum[7:0]);
            else if (st_q.idx != CHK1_HI && st_q.idx < CHK2_HI)
                st_d.sum = st_q.sum + SW'(cur_byte);
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST_IDX) st_d.active = 1'b0;
        end
    end

    function automatic bind_mode_e bind_bode_cast(input logic [1:0] m);
        return bind_mode_e'(m);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, idx: '0, sum: '0, id: '0, cnt: '0, mode: MODE_LEG22};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.active;
    assign out_data_o  = cur_byte;
    assign out_last_o  = st_q.active && (st_q.idx == LAST_IDX);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

    assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    assert_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_last_o) |=> !out_valid_o);

    assert_start_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(start_i));

    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && start_i && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: tb/bind_frame_gen_bench.sv
module bind_frame_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] id_i = '0;
    logic [3:0]  chan_cnt_i = '0;
    logic [1:0]  mode_i = '0;
    logic [7:0]  out_data_o;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic        out_last_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_f [16];
    logic [7:0] got_f [16];

    always #2 clk = ~clk;

    bind_frame_gen u_bind_frame_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_i(id_i),
        .chan_cnt_i(chan_cnt_i), .mode_i(mode_i), .out_data_o(out_data_o),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_last_o(out_last_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic build_exp(input logic [31:0] id, input logic [3:0] cnt, input logic [1:0] mode);
        logic [15:0] s = 16'd368;
        for (int i = 0; i < 4; i++) begin
            exp_f[i]   = ~id[i*8 +: 8];
            exp_f[i+4] = ~id[i*8 +: 8];
        end
        for (int i = 0; i < 8; i++) s = s + 16'(exp_f[i]);
        exp_f[8]  = s[15:8];
        exp_f[9]  = s[7:0];
        exp_f[10] = 8'h01;
        exp_f[11] = 8'(cnt);
        case (mode)
            2'd0: exp_f[12] = (cnt < 8) ? 8'h01 : 8'h02;
            2'd1: exp_f[12] = 8'h12;
            2'd2: exp_f[12] = (cnt < 8) ? 8'hA2 : 8'hB2;
            default: exp_f[12] = 8'hB2;
        endcase
        exp_f[13] = 8'h00;
        for (int i = 8; i < 14; i++) s = s + 16'(exp_f[i]);
        exp_f[14] = s[15:8];
        exp_f[15] = s[7:0];
    endtask

    function automatic string req_of(input int i, input logic [1:0] mode);
        if (i < 8) return "R2";
        if (i < 10) return "R3";
        if (i == 12) return (mode < 2) ? "R5" : "R6";
        if (i < 14) return "R4";
        return "R7";
    endfunction

    task automatic kick(input logic [31:0] id, input logic [3:0] cnt, input logic [1:0] mode);
        @(negedge clk);
        id_i = id; chan_cnt_i = cnt; mode_i = mode; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // collects a frame; stall_per > 0 drops ready every stall_per-th cycle
    task automatic collect(input int stall_per, input int from, output int n);
        int cyc = 0;
        n = from;
        while (n < 16 && cyc < 200) begin
            out_ready_i = (stall_per == 0) || ((cyc % stall_per) != 0);
            if (out_valid_o) begin
                check(out_last_o == (n == 15), "R9", int'(out_last_o), int'(n == 15));
                if (out_ready_i) begin
                    got_f[n] = out_data_o;
                    n++;
                end
            end
            cyc++;
            @(negedge clk);
        end
        out_ready_i = 1'b0;
    endtask

    task automatic compare(input logic [1:0] mode);
        for (int i = 0; i < 16; i++)
            check(got_f[i] == exp_f[i], req_of(i, mode), int'(got_f[i]), int'(exp_f[i]));
    endtask

    task automatic t_frame(input logic [31:0] id, input logic [3:0] cnt, input logic [1:0] mode,
                           input int stall_per);
        int n;
        build_exp(id, cnt, mode);
        kick(id, cnt, mode);
        collect(stall_per, 0, n);
        check(n == 16, "R9", n, 16);
        compare(mode);
        check(!out_valid_o, "R9", int'(out_valid_o), 0);
    endtask

    task automatic t_reset_idle;
        repeat (3) @(negedge clk);
        check(!out_valid_o && !out_last_o, "R1", int'({out_valid_o, out_last_o}), 0);
    endtask

    task automatic t_hold;
        logic [7:0] first;
        build_exp(32'hA5C3_0F11, 4'd7, 2'd2);
        kick(32'hA5C3_0F11, 4'd7, 2'd2);
        first = out_data_o;
        check(out_valid_o && first == exp_f[0], "R8", int'(first), int'(exp_f[0]));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid_o && out_data_o == first && !out_last_o, "R8", int'(out_data_o), int'(first));
        end
        begin
            int n;
            collect(0, 0, n);
            compare(2'd2);
        end
    endtask

    task automatic t_ignore_start;
        int n;
        build_exp(32'h1234_5678, 4'd9, 2'd0);
        kick(32'h1234_5678, 4'd9, 2'd0);
        out_ready_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            got_f[k] = out_data_o;
            @(negedge clk);
        end
        out_ready_i = 1'b0;
        id_i = 32'hDEAD_BEEF; chan_cnt_i = 4'd4; mode_i = 2'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(out_data_o == exp_f[5], "R10", int'(out_data_o), int'(exp_f[5]));
        collect(3, 5, n);
        check(n == 16, "R10", n, 16);
        for (int i = 0; i < 16; i++)
            check(got_f[i] == exp_f[i], "R10", int'(got_f[i]), int'(exp_f[i]));
        @(negedge clk);
        check(!out_valid_o, "R10", int'(out_valid_o), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_idle();
        rst_n = 1'b1;
        t_reset_idle();
        t_frame(32'h0000_0000, 4'd6, 2'd0, 0);
        t_frame(32'hFFFF_FFFF, 4'd12, 2'd0, 0);
        t_frame(32'h8123_4C5D, 4'd8, 2'd1, 2);
        t_frame(32'h0102_0304, 4'd5, 2'd2, 0);
        t_frame(32'hF00D_CAFE, 4'd10, 2'd2, 3);
        t_frame(32'h0F0F_0F0F, 4'd4, 2'd3, 0);
        t_frame(32'h7E00_00FF, 4'd7, 2'd0, 0);
        t_hold();
        t_ignore_start();
        t_reset_idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule